// File: doc/BRIEF.md
# Set/Clear Software Reset Controller

This block drives one reset line per module for a large number of modules, arranged in banks of equal width. Software asserts a module's reset by writing a one to its bit through a set channel. It releases the reset by writing a one to the same bit through a separate clear channel. Bits written as zero on either channel leave their modules alone, so no read-modify-write sequence is needed and concurrent agents cannot corrupt each other's bits. Module number m belongs to bank m / BANK_W at bit m % BANK_W, and drives `modRst[m]`.

A release only takes effect once the reset has been held long enough for the slowest logic in the target module to see it. That minimum is MIN_TICKS pulses of `slowTick`, a single-cycle strobe derived from a slow reference clock. A clear that arrives too early is remembered. It completes on the clock edge that samples the last required tick. A read port returns the live reset state of a bank, so software can poll it.

Top module: `swrst_unit`

## Requirements
- R1: While `rstN` is low and after it rises, every `modRst` bit is 0 and no release is pending; a clear followed by ticks without any set leaves all outputs at 0.
- R2: A set write (`setWrEn`=1, `setBank`=b < NUM_BANKS) drives `modRst[b*BANK_W+k]` to 1 on the next edge for each k with `setData[k]`=1; bits with `setData[k]`=0 keep their value.
- R3: A clear write to a held module whose minimum hold is complete releases it on the next edge; zero bits of `clrData` and clears of modules not in reset have no effect.
- R4: A held module is released no earlier than the edge that samples its MIN_TICKS-th `slowTick` pulse counted after the set write; a tick in the same cycle as the set is not counted.
- R5: A clear that arrives before the minimum is complete stays pending and releases the module on the edge that samples the MIN_TICKS-th tick, with no further write.
- R6: If the same bit is set and cleared in one cycle, the set wins and any pending release is dropped; a repeated set on a held module restarts its hold count and drops its pending release.
- R7: With `rdSel`=0 and `rdBank`=b < NUM_BANKS, `rdData` equals `modRst[b*BANK_W +: BANK_W]` combinationally in the same cycle.
- R8: With `rdSel`=1, or with `rdBank` not below NUM_BANKS, `rdData` is 0; set or clear writes naming a bank not below NUM_BANKS change nothing.
- R9: `modRst` changes only on an edge that samples a set write, a clear write or a `slowTick` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and state clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| slowTick | input | 1 | One-cycle pulse per slow reference period, synchronous to clk |
| setWrEn | input | 1 | Set channel write strobe |
| setBank | input | BIDX_W | Bank addressed by the set channel |
| setData | input | BANK_W | Ones assert the matching module resets |
| clrWrEn | input | 1 | Clear channel write strobe |
| clrBank | input | BIDX_W | Bank addressed by the clear channel |
| clrData | input | BANK_W | Ones request release of the matching module resets |
| rdBank | input | BIDX_W | Bank selected for read |
| rdSel | input | 1 | 0 reads the reset state, 1 reads the clear register (always 0) |
| rdData | output | BANK_W | Read data, combinational |
| modRst | output | NUM_BANKS*BANK_W | Per-module reset outputs, active high |

## Verification
A wrong hold count or a stale pending flag inside a cell shows at `modRst` either as a release one tick too early, or as a release that never comes or arrives without a clear. Each such error becomes visible on the edge that samples the deciding tick or write, so a per-step comparison catches it within one cycle. Every module is walked through the early-clear, ripe-clear, collision and restart orders. A long pseudo-random mix of writes, ticks and reads then exposes a cell that is wired to the wrong bank or bit, because its output or read-back bit diverges on the first stimulus that touches it.

// File: rtl/swrst_pkg.sv
package swrst_pkg;

  // Strobes passed from the decode control to the per-module datapath.
  typedef struct packed {
    logic setGo;   // set channel addresses an existing bank
    logic clrGo;   // clear channel addresses an existing bank
    logic tickGo;  // slow reference tick this cycle
    logic rdZero;  // read returns zero (clear register or missing bank)
  } swrst_strobe_t;

  function automatic int bankIdxWidth(input int banks);
    return (banks > 1) ? $clog2(banks) : 1;
  endfunction

  function automatic int holdCntWidth(input int ticks);
    return (ticks > 1) ? $clog2(ticks + 1) : 1;
  endfunction

endpackage

// File: rtl/swrst_control.sv
module swrst_control
  import swrst_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int BIDX_W    = bankIdxWidth(NUM_BANKS)
) (
  input  logic              slowTick,
  input  logic              setWrEn,
  input  logic [BIDX_W-1:0] setBank,
  input  logic              clrWrEn,
  input  logic [BIDX_W-1:0] clrBank,
  input  logic [BIDX_W-1:0] rdBank,
  input  logic              rdSel,
  output swrst_strobe_t     strobe
);

  localparam int LAST_BANK = NUM_BANKS - 1;

  logic setInRange;
  logic clrInRange;
  logic rdInRange;

  // A bank index past the last bank is a hole in the map: writes drop, reads give zero.
  always_comb begin
    setInRange = (int'(setBank) <= LAST_BANK);
    clrInRange = (int'(clrBank) <= LAST_BANK);
    rdInRange  = (int'(rdBank)  <= LAST_BANK);
  end

  always_comb begin
    strobe.setGo  = setWrEn && setInRange;
    strobe.clrGo  = clrWrEn && clrInRange;
    strobe.tickGo = slowTick;
    strobe.rdZero = rdSel || !rdInRange;
  end

endmodule

// File: rtl/swrst_datapath.sv
module swrst_datapath
  import swrst_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int BANK_W    = 32,
  parameter int MIN_TICKS = 2,
  parameter int BIDX_W    = bankIdxWidth(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  swrst_strobe_t               strobe,
  input  logic [BIDX_W-1:0]           setBank,
  input  logic [BANK_W-1:0]           setData,
  input  logic [BIDX_W-1:0]           clrBank,
  input  logic [BANK_W-1:0]           clrData,
  input  logic [BIDX_W-1:0]           rdBank,
  output logic [BANK_W-1:0]           rdData,
  output logic [NUM_BANKS*BANK_W-1:0] rstQ
);

  localparam int CNT_W = holdCntWidth(MIN_TICKS);
  localparam logic [CNT_W-1:0] HOLD_FULL = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_TICKS - 1);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic setBankHit;
    logic clrBankHit;

    always_comb begin
      setBankHit = strobe.setGo && (setBank == BIDX_W'(b));
      clrBankHit = strobe.clrGo && (clrBank == BIDX_W'(b));
    end

    for (genvar k = 0; k < BANK_W; k++) begin : gBit
      logic             held;
      logic             pend;
      logic [CNT_W-1:0] holdCnt;
      logic             setHit;
      logic             clrHit;
      logic             ripe;

      always_comb begin
        setHit = setBankHit && setData[k];
        clrHit = clrBankHit && clrData[k];
        // Minimum hold is met now, or is met by the tick sampled on this edge.
        ripe   = (holdCnt == HOLD_FULL) ||
                 (strobe.tickGo && (holdCnt == HOLD_LAST));
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          held    <= 1'b0;
          pend    <= 1'b0;
          holdCnt <= '0;
        end else if (setHit) begin
          held    <= 1'b1;
          pend    <= 1'b0;
          holdCnt <= '0;
        end else if (held) begin
          if ((clrHit || pend) && ripe) begin
            held    <= 1'b0;
            pend    <= 1'b0;
            holdCnt <= '0;
          end else begin
            if (clrHit) pend <= 1'b1;
            if (strobe.tickGo && (holdCnt != HOLD_FULL)) holdCnt <= holdCnt + 1'b1;
          end
        end
      end

      assign rstQ[b*BANK_W + k] = held;
    end
  end

  always_comb begin
    rdData = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!strobe.rdZero && (rdBank == BIDX_W'(b))) rdData = rstQ[b*BANK_W +: BANK_W];
    end
  end

endmodule

// File: rtl/swrst_unit.sv
module swrst_unit
  import swrst_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int BANK_W    = 32,
  parameter int MIN_TICKS = 2,
  parameter int BIDX_W    = bankIdxWidth(NUM_BANKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        slowTick,
  input  logic                        setWrEn,
  input  logic [BIDX_W-1:0]           setBank,
  input  logic [BANK_W-1:0]           setData,
  input  logic                        clrWrEn,
  input  logic [BIDX_W-1:0]           clrBank,
  input  logic [BANK_W-1:0]           clrData,
  input  logic [BIDX_W-1:0]           rdBank,
  input  logic                        rdSel,
  output logic [BANK_W-1:0]           rdData,
  output logic [NUM_BANKS*BANK_W-1:0] modRst
);

  swrst_strobe_t strobe;

  swrst_control #(
    .NUM_BANKS(NUM_BANKS),
    .BIDX_W   (BIDX_W)
  ) uControl (
    .slowTick(slowTick),
    .setWrEn (setWrEn),
    .setBank (setBank),
    .clrWrEn (clrWrEn),
    .clrBank (clrBank),
    .rdBank  (rdBank),
    .rdSel   (rdSel),
    .strobe  (strobe)
  );

  swrst_datapath #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .MIN_TICKS(MIN_TICKS),
    .BIDX_W   (BIDX_W)
  ) uDatapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .setBank(setBank),
    .setData(setData),
    .clrBank(clrBank),
    .clrData(clrData),
    .rdBank (rdBank),
    .rdData (rdData),
    .rstQ   (modRst)
  );

endmodule

// File: rtl/swrst_unit_chk.sv
module swrst_unit_chk #(
  parameter int NUM_BANKS = 12,
  parameter int BANK_W    = 32,
  parameter int BIDX_W    = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        slowTick,
  input logic                        setWrEn,
  input logic [BIDX_W-1:0]           setBank,
  input logic [BANK_W-1:0]           setData,
  input logic                        clrWrEn,
  input logic [BIDX_W-1:0]           clrBank,
  input logic [BANK_W-1:0]           clrData,
  input logic [BIDX_W-1:0]           rdBank,
  input logic                        rdSel,
  input logic [BANK_W-1:0]           rdData,
  input logic [NUM_BANKS*BANK_W-1:0] modRst
);

  localparam int N = NUM_BANKS * BANK_W;

  logic [N-1:0]      setMask;
  logic [N-1:0]      clrMask;
  logic [BANK_W-1:0] rdSlice;
  logic              rdValid;

  always_comb begin
    setMask = '0;
    clrMask = '0;
    rdSlice = '0;
    rdValid = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (setWrEn && (setBank == BIDX_W'(b))) setMask[b*BANK_W +: BANK_W] = setData;
      if (clrWrEn && (clrBank == BIDX_W'(b))) clrMask[b*BANK_W +: BANK_W] = clrData;
      if (rdBank == BIDX_W'(b)) begin
        rdSlice = modRst[b*BANK_W +: BANK_W];
        rdValid = 1'b1;
      end
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |-> (modRst == '0));

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setMask != '0) |=> ((modRst & $past(setMask)) == $past(setMask)));

  // R2
  rise_needs_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (((modRst & ~$past(modRst)) & ~$past(setMask)) == '0));

  // R6
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((setMask & clrMask) != '0) |=> ((modRst & $past(setMask & clrMask)) == $past(setMask & clrMask)));

  // R9
  quiet_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!slowTick && !clrWrEn) |=> (($past(modRst) & ~modRst) == '0));

  // R7
  read_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdSel && rdValid) |-> (rdData == rdSlice));

  // R8
  read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdSel || !rdValid) |-> (rdData == '0));

endmodule

bind swrst_unit swrst_unit_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W),
  .BIDX_W   (BIDX_W)
) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .slowTick(slowTick),
  .setWrEn (setWrEn),
  .setBank (setBank),
  .setData (setData),
  .clrWrEn (clrWrEn),
  .clrBank (clrBank),
  .clrData (clrData),
  .rdBank  (rdBank),
  .rdSel   (rdSel),
  .rdData  (rdData),
  .modRst  (modRst)
);

// File: tb/sim_swrst_unit.sv
`timescale 1ns/1ps
module sim_swrst_unit;

  localparam int NB = 3;
  localparam int W  = 8;
  localparam int MT = 2;
  localparam int BW = 2;
  localparam int N  = NB * W;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          slowTick = 1'b0;
  logic          setWrEn = 1'b0;
  logic [BW-1:0] setBank = '0;
  logic [W-1:0]  setData = '0;
  logic          clrWrEn = 1'b0;
  logic [BW-1:0] clrBank = '0;
  logic [W-1:0]  clrData = '0;
  logic [BW-1:0] rdBank = '0;
  logic          rdSel = 1'b0;
  logic [W-1:0]  rdData;
  logic [N-1:0]  modRst;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  bit mRst  [N];
  int mCnt  [N];
  bit mPend [N];

  always #4 clk = ~clk;

  swrst_unit #(.NUM_BANKS(NB), .BANK_W(W), .MIN_TICKS(MT), .BIDX_W(BW)) u0 (
    .clk(clk), .rstN(rstN), .slowTick(slowTick),
    .setWrEn(setWrEn), .setBank(setBank), .setData(setData),
    .clrWrEn(clrWrEn), .clrBank(clrBank), .clrData(clrData),
    .rdBank(rdBank), .rdSel(rdSel), .rdData(rdData), .modRst(modRst)
  );

  function automatic logic [N-1:0] modelVec();
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = mRst[i];
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock of stimulus: inputs are driven at the falling edge, the model
  // advances as the requirements dictate, results are sampled at the next falling edge.
  task automatic step(input bit se, input int sb, input logic [W-1:0] sd,
                      input bit ce, input int cb, input logic [W-1:0] cd,
                      input bit tk, input int rb, input bit rs, input string req);
    logic [N-1:0] expVec;
    logic [W-1:0] expRd;
    setWrEn = se; setBank = BW'(sb); setData = sd;
    clrWrEn = ce; clrBank = BW'(cb); clrData = cd;
    slowTick = tk; rdBank = BW'(rb); rdSel = rs;
    for (int i = 0; i < N; i++) begin
      bit s, c, ripe;
      s = se && (sb < NB) && (sb == i / W) && sd[i % W];
      c = ce && (cb < NB) && (cb == i / W) && cd[i % W];
      if (s) begin
        mRst[i] = 1; mCnt[i] = 0; mPend[i] = 0;
      end else if (mRst[i]) begin
        ripe = (mCnt[i] >= MT) || (tk && mCnt[i] == MT - 1);
        if ((c || mPend[i]) && ripe) begin
          mRst[i] = 0; mPend[i] = 0; mCnt[i] = 0;
        end else begin
          if (c) mPend[i] = 1;
          if (tk && mCnt[i] < MT) mCnt[i]++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    setWrEn = 0; clrWrEn = 0; slowTick = 0;
    expVec = modelVec();
    check(modRst === expVec, req, modRst, expVec);
    expRd = (rs || rb >= NB) ? '0 : expVec[rb*W +: W];
    check(rdData === expRd, rs ? "R8 read" : "R7 read", N'(rdData), N'(expRd));
  endtask

  task automatic idle(input string req);
    step(0, 0, '0, 0, 0, '0, 0, 0, 0, req);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin mRst[i] = 0; mCnt[i] = 0; mPend[i] = 0; end
    #3;
    check(modRst === '0, "R1 during reset", modRst, '0);
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(modRst === '0, "R1 after reset", modRst, '0);
    // R1: nothing pending after reset
    step(0, 0, '0, 1, 0, 8'hFF, 0, 0, 0, "R1 clear idle");
    step(0, 0, '0, 0, 0, '0, 1, 0, 0, "R1 tick");
    step(0, 0, '0, 0, 0, '0, 1, 0, 0, "R1 tick");

    // Every module through the early-clear order
    for (int m = 0; m < N; m++) begin
      logic [W-1:0] msk;
      int b;
      msk = W'(1) << (m % W);
      b = m / W;
      step(1, b, msk, 0, 0, '0, 0, b, 0, "R2 set");
      step(0, 0, '0, 1, b, msk, 0, b, 0, "R5 early clear held");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R4 first tick held");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R5 pending release");
    end

    // Every module through the ripe-clear order, with a read of the clear register
    for (int m = 0; m < N; m++) begin
      logic [W-1:0] msk;
      int b;
      msk = W'(1) << (m % W);
      b = m / W;
      step(1, b, msk, 0, 0, '0, 1, b, 0, "R4 tick with set ignored");
      step(0, 0, '0, 0, 0, '0, 1, b, 1, "R8 clear reg reads zero");
      step(0, 0, '0, 1, b, msk, 0, b, 0, "R4 one tick not enough");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R5 release on second tick");
      step(1, b, msk, 0, 0, '0, 1, b, 0, "R2 set");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R4 tick");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R4 tick");
      idle("R9 idle holds");
      step(0, 0, '0, 1, b, msk, 0, b, 0, "R3 ripe clear");
    end

    // Collision and restart on each bank, full byte
    for (int b = 0; b < NB; b++) begin
      step(1, b, 8'hA5, 1, b, 8'hFF, 0, b, 0, "R6 set beats clear");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R6 no pending after collision");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R6 still held");
      step(0, 0, '0, 1, b, 8'h0F, 0, b, 0, "R3 zero bits ignored");
      step(0, 0, '0, 1, b, 8'hF0, 0, b, 0, "R3 release rest");
      step(1, b, 8'h3C, 0, 0, '0, 0, b, 0, "R2 set");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R6 tick");
      step(1, b, 8'h3C, 1, b, 8'h3C, 0, b, 0, "R6 restart");
      step(0, 0, '0, 1, b, 8'h3C, 1, b, 0, "R6 restarted count held");
      step(0, 0, '0, 0, 0, '0, 1, b, 0, "R5 pending after restart");
    end

    // Missing bank and reads
    step(1, 3, 8'hFF, 0, 0, '0, 0, 3, 0, "R8 set missing bank");
    step(1, 1, 8'h81, 0, 0, '0, 0, 1, 0, "R2 set");
    step(0, 0, '0, 0, 0, '0, 1, 1, 0, "R4 tick");
    step(0, 0, '0, 0, 0, '0, 1, 1, 0, "R4 tick");
    step(0, 0, '0, 1, 3, 8'hFF, 0, 3, 0, "R8 clear missing bank");
    step(0, 0, '0, 0, 0, '0, 0, 1, 1, "R8 clear reg reads zero");

    // Pseudo-random mix
    begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      for (int t = 0; t < 3000; t++) begin
        bit se, ce, tk, rs;
        int sb, cb, rb;
        logic [W-1:0] sd, cd;
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        se = (lfsr[2:0] == 3'd0);
        ce = (lfsr[5:3] <= 3'd1);
        tk = (lfsr[8:6] == 3'd7);
        sb = int'(lfsr[10:9]);
        cb = int'(lfsr[12:11]);
        rb = int'(lfsr[14:13]);
        rs = (lfsr[17:15] == 3'd0);
        sd = lfsr[25:18];
        cd = {lfsr[31:26], lfsr[1:0]};
        step(se, sb, sd, ce, cb, cd, tk, rb, rs, "R9 mixed");
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule